// File: doc/BRIEF.md
# Four-bit function-select ALU slice

A purely combinational four-bit arithmetic and logic slice. A five-bit control word picks one of 32 functions: a mode bit and a four-bit select code. With the mode bit high, the slice applies one of the sixteen possible two-input Boolean functions to each bit pair of the operands. Each result bit depends only on the two operand bits in the same position. With the mode bit low, it applies one of sixteen arithmetic functions to the two four-bit words. An active carry input adds exactly one to the result.

Every function is built from two per-bit terms. An OR-type term is formed from A, B and the low select bits. An AND-type term is formed from A, B and the high select bits. All carries come from a full four-bit lookahead over these terms, with no ripple path inside the slice. Group propagate and group generate outputs do not depend on the carry input, so wider words can be built either by chaining carry out to carry in or by feeding an external lookahead unit. An all-ones flag on the result makes the slice usable as a comparator in subtract mode.

Top module: `alu4_slice`

## Requirements
- R1: With mode_logic = 1, f is set by sel (written as a 4-bit number) as follows: 0 ~A, 1 ~(A|B), 2 ~A&B, 3 all zeros, 4 ~(A&B), 5 ~B, 6 A^B, 7 A&~B, 8 ~A|B, 9 ~(A^B), 10 B, 11 A&B, 12 all ones, 13 A|~B, 14 A|B, 15 A.
- R2: With mode_logic = 1, carry_in has no effect on f.
- R3: With mode_logic = 0, f is the low four bits of T1 + T2 + carry_in, where (T1, T2) is chosen by sel: 0 (A,0), 1 (A|B,0), 2 (A|~B,0), 3 (0,15), 4 (A,A&~B), 5 (A|B,A&~B), 6 (A,~B), 7 (A&~B,15), 8 (A,A&B), 9 (A,B), 10 (A|~B,A&B), 11 (A&B,15), 12 (A,A), 13 (A|B,A), 14 (A|~B,A), 15 (A,15). Adding 15 stands for "minus one" modulo 16.
- R4: In the subtract code (mode_logic = 0, sel = 6), carry_out = 1 means no borrow: it is high exactly when A >= B with carry_in = 1, and when A > B with carry_in = 0. With carry_in = 0, all_ones is high exactly when A equals B.
- R5: grp_g is high exactly when the unwrapped sum T1 + T2 of R3's table for the current sel is 16 or more. grp_p OR grp_g is high exactly when that sum is 15 or more. Neither output depends on carry_in.
- R6: carry_out equals grp_g OR (grp_p AND carry_in) in both modes, that is, T1 + T2 + carry_in >= 16.
- R7: all_ones is high exactly when f is 4'b1111.
- R8: With mode_logic = 0, sel 9 gives A + B + carry_in, and sel 12 gives A shifted left by one with carry_in entering bit 0 and A[3] leaving on carry_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | 4 | Operand A |
| b | input | 4 | Operand B |
| sel | input | 4 | Function select code |
| mode_logic | input | 1 | 1 = bitwise logic, 0 = arithmetic |
| carry_in | input | 1 | Carry input, 1 = carry present |
| f | output | 4 | Function result |
| carry_out | output | 1 | Carry output for ripple chaining |
| grp_p | output | 1 | Group propagate, independent of carry_in |
| grp_g | output | 1 | Group generate, independent of carry_in |
| all_ones | output | 1 | High when every bit of f is 1 |

## Verification
The slice has no parameters, so the bench builds it with its fixed four-bit width. At this width the whole input space is small: all 32 control words, both carry values and all 256 operand pairs, which is 16384 vectors. Every entry of both function tables is therefore checked, together with the exact boundaries of the propagate and generate outputs at sums 15 and 16 and the borrow and equality behaviour of the subtract code.

// File: rtl/alu4_slice.sv
module alu4_slice (
  input  logic [3:0] a,
  input  logic [3:0] b,
  input  logic [3:0] sel,
  input  logic       mode_logic,
  input  logic       carry_in,
  output logic [3:0] f,
  output logic       carry_out,
  output logic       grp_p,
  output logic       grp_g,
  output logic       all_ones
);
  logic [3:0] x, y, h, c;

  assign x = a | (b & {4{sel[0]}}) | (~b & {4{sel[1]}});
  assign y = (a & ~b & {4{sel[2]}}) | (a & b & {4{sel[3]}});
  assign h = x ^ y;

  assign c[0] = carry_in;
  assign c[1] = y[0] | (x[0] & carry_in);
  assign c[2] = y[1] | (x[1] & y[0]) | (x[1] & x[0] & carry_in);
  assign c[3] = y[2] | (x[2] & y[1]) | (x[2] & x[1] & y[0])
              | (x[2] & x[1] & x[0] & carry_in);

  assign grp_p = &x;
  assign grp_g = y[3] | (x[3] & y[2]) | (x[3] & x[2] & y[1])
               | (x[3] & x[2] & x[1] & y[0]);

  assign carry_out = y[3] | (x[3] & y[2]) | (x[3] & x[2] & y[1])
                   | (x[3] & x[2] & x[1] & y[0])
                   | (x[3] & x[2] & x[1] & x[0] & carry_in);

  assign f        = mode_logic ? ~h : (h ^ c);
  assign all_ones = &f;
endmodule

// File: rtl/alu4_slice_chk.sv
module alu4_slice_chk (
  input logic [3:0] a,
  input logic [3:0] b,
  input logic [3:0] sel,
  input logic       mode_logic,
  input logic       carry_in,
  input logic [3:0] f,
  input logic       carry_out,
  input logic       grp_p,
  input logic       grp_g,
  input logic       all_ones
);
  logic [4:0] add_sum;
  assign add_sum = {1'b0, a} + {1'b0, b} + {4'd0, carry_in};

  always_comb begin
    if (grp_g)
      a_r6_gen_forces_carry: assert (carry_out) else $error("G without carry out");
    if (!grp_p && !grp_g)
      a_r6_no_pg_no_carry: assert (!carry_out) else $error("carry out without P or G");
    if (!mode_logic && sel == 4'd6 && !carry_in)
      a_r4_equal_flag: assert (all_ones == (a == b)) else $error("equality flag wrong");
    if (!mode_logic && sel == 4'd6)
      a_r4_no_borrow: assert (carry_out == (carry_in ? (a >= b) : (a > b))) else $error("borrow wrong");
    if (!mode_logic && sel == 4'd9)
      a_r8_add: assert ({carry_out, f} == add_sum) else $error("add wrong");
    if (!mode_logic && sel == 4'd12)
      a_r8_double: assert ({carry_out, f} == {a, carry_in}) else $error("double wrong");
    if (mode_logic && sel == 4'd11)
      a_r1_and: assert (f == (a & b)) else $error("logic AND wrong");
    if (!mode_logic && grp_p && !grp_g)
      a_r5_sum_fifteen: assert (f == (carry_in ? 4'd0 : 4'd15)) else $error("P alone not sum 15");
  end
endmodule

bind alu4_slice alu4_slice_chk u_chk (
  .a(a), .b(b), .sel(sel), .mode_logic(mode_logic), .carry_in(carry_in),
  .f(f), .carry_out(carry_out), .grp_p(grp_p), .grp_g(grp_g), .all_ones(all_ones)
);

// File: tb/sim_alu4_slice.sv
`timescale 1ns/1ps
module sim_alu4_slice;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [3:0] a = 4'd0, b = 4'd0, sel = 4'd0;
  logic       mode_logic = 1'b0, carry_in = 1'b0;
  logic [3:0] f;
  logic       carry_out, grp_p, grp_g, all_ones;

  alu4_slice u0 (.a(a), .b(b), .sel(sel), .mode_logic(mode_logic), .carry_in(carry_in),
                 .f(f), .carry_out(carry_out), .grp_p(grp_p), .grp_g(grp_g), .all_ones(all_ones));

  typedef struct {
    logic [3:0] a, b, s;
    logic m, ci;
    logic [3:0] f;
    logic co, pg, g, eq;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  function automatic logic [3:0] logic_ref(input logic [3:0] s, input logic [3:0] x, input logic [3:0] y);
    case (s)
      4'd0: return ~x;       4'd1: return ~(x | y);
      4'd2: return ~x & y;   4'd3: return 4'h0;
      4'd4: return ~(x & y); 4'd5: return ~y;
      4'd6: return x ^ y;    4'd7: return x & ~y;
      4'd8: return ~x | y;   4'd9: return ~(x ^ y);
      4'd10: return y;       4'd11: return x & y;
      4'd12: return 4'hF;    4'd13: return x | ~y;
      4'd14: return x | y;   default: return x;
    endcase
  endfunction

  function automatic logic [4:0] arith_sum(input logic [3:0] s, input logic [3:0] x, input logic [3:0] y);
    logic [3:0] t1, t2;
    case (s)
      4'd0:  begin t1 = x;      t2 = 4'd0;    end
      4'd1:  begin t1 = x | y;  t2 = 4'd0;    end
      4'd2:  begin t1 = x | ~y; t2 = 4'd0;    end
      4'd3:  begin t1 = 4'd0;   t2 = 4'd15;   end
      4'd4:  begin t1 = x;      t2 = x & ~y;  end
      4'd5:  begin t1 = x | y;  t2 = x & ~y;  end
      4'd6:  begin t1 = x;      t2 = ~y;      end
      4'd7:  begin t1 = x & ~y; t2 = 4'd15;   end
      4'd8:  begin t1 = x;      t2 = x & y;   end
      4'd9:  begin t1 = x;      t2 = y;       end
      4'd10: begin t1 = x | ~y; t2 = x & y;   end
      4'd11: begin t1 = x & y;  t2 = 4'd15;   end
      4'd12: begin t1 = x;      t2 = x;       end
      4'd13: begin t1 = x | y;  t2 = x;       end
      4'd14: begin t1 = x | ~y; t2 = x;       end
      default: begin t1 = x;    t2 = 4'd15;   end
    endcase
    return {1'b0, t1} + {1'b0, t2};
  endfunction

  task automatic drive(input logic [3:0] ta, input logic [3:0] tb, input logic [3:0] ts,
                       input logic tm, input logic tci);
    exp_t e;
    logic [4:0] sum, tot;
    @(negedge clk);
    sum = arith_sum(ts, ta, tb);
    tot = sum + {4'd0, tci};
    e.a = ta; e.b = tb; e.s = ts; e.m = tm; e.ci = tci;
    e.f  = tm ? logic_ref(ts, ta, tb) : tot[3:0];
    e.co = (tot >= 5'd16);
    e.g  = (sum >= 5'd16);
    e.pg = (sum >= 5'd15);
    e.eq = (e.f == 4'hF);
    a = ta; b = tb; sel = ts; mode_logic = tm; carry_in = tci;
    q.push_back(e);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int expv, input exp_t e);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s m=%0d s=%0d a=%0d b=%0d ci=%0d actual=%0d expected=%0d",
               req, e.m, e.s, e.a, e.b, e.ci, act, expv);
    end
  endtask

  always @(posedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      if (e.m)
        check(f == e.f, e.ci ? "R2 logic f with carry_in" : "R1 logic f", f, e.f, e);
      else
        check(f == e.f, "R3 arith f", f, e.f, e);
      check(grp_g == e.g, "R5 grp_g", grp_g, e.g, e);
      check((grp_p | grp_g) == e.pg, "R5 grp_p|grp_g", grp_p | grp_g, e.pg, e);
      check(carry_out == e.co, "R6 carry_out", carry_out, e.co, e);
      check(carry_out == (grp_g | (grp_p & e.ci)), "R6 carry_out vs P/G", carry_out,
            grp_g | (grp_p & e.ci), e);
      check(all_ones == e.eq, "R7 all_ones", all_ones, e.eq, e);
      if (!e.m && e.s == 4'd6) begin
        check(carry_out == (e.ci ? (e.a >= e.b) : (e.a > e.b)), "R4 no-borrow", carry_out,
              e.ci ? (e.a >= e.b) : (e.a > e.b), e);
        if (!e.ci)
          check(all_ones == (e.a == e.b), "R4 equality", all_ones, e.a == e.b, e);
      end
      if (!e.m && e.s == 4'd9)
        check({carry_out, f} == ({1'b0, e.a} + {1'b0, e.b} + {4'd0, e.ci}), "R8 add",
              {carry_out, f}, {1'b0, e.a} + {1'b0, e.b} + {4'd0, e.ci}, e);
      if (!e.m && e.s == 4'd12)
        check({carry_out, f} == {e.a, e.ci}, "R8 double", {carry_out, f}, {e.a, e.ci}, e);
    end
  end

  initial begin
    fork
      begin
        drive(4'd0, 4'd0, 4'd0, 1'b0, 1'b0);
        for (int m = 0; m < 2; m++)
          for (int s = 0; s < 16; s++)
            for (int ci = 0; ci < 2; ci++)
              for (int av = 0; av < 16; av++)
                for (int bv = 0; bv < 16; bv++)
                  drive(av[3:0], bv[3:0], s[3:0], m[0], ci[0]);
        repeat (3) @(posedge clk);
        done = 1'b1;
      end
      begin
        repeat (100000) @(posedge clk);
        if (!done) begin
          n_chk++;
          n_bad++;
          $display("FAIL watchdog actual=timeout expected=completion");
        end
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule